// File: doc/BRIEF.md
# Overcurrent Alert and Status Latch

This block gathers two independent overcurrent indications and turns them into one status byte and an active-low, open-drain alert request. The first indication is digital: each current result delivered by the conversion controller is compared with a programmable byte threshold. The comparison can fire on a single result or only after a run of consecutive high results. The second indication is an asynchronous comparator input from the analog side. It is first brought into the clock domain.

A bus front end writes three byte-wide settings through a simple write port: an enable byte, the threshold byte and a control byte that carries a software-off request. Each source has a live status bit and a sticky latched bit. The latched bits stay set until a clear command is written. That command removes only the alerts whose cause is no longer present. The alert request is an enable for an external pull-down, and the block never drives the alert line high.

Top module: `oc_alert_status`

## Requirements
- R1: After reset the status byte is 0x00, the pull-down request is low, the threshold is 0xFF and only enable bit 2 (comparator latch) is set.
- R2: Status bit 0 holds the result of the most recent strobed current code: 1 when code bits [11:4] are strictly greater than the threshold, otherwise 0. It changes only on a strobe.
- R3: With enable bit 0 set, a live ADC compare of 1 sets latched status bit 1 one cycle later.
- R4: With only enable bit 1 set, status bit 1 latches one cycle after the fourth consecutive above-threshold result. Any result at or below the threshold restarts the run.
- R5: Comparator input level appears on status bit 2 two cycles after it is sampled. With enable bit 2 set, latched status bit 3 sets one cycle after that.
- R6: With enable bit 2 clear, a comparator overcurrent never sets status bit 3.
- R7: Status bit 4 equals control bit 0 ANDed with enable bit 3. While it is 1, latched status bit 5 sets one cycle later.
- R8: Writing the enable byte with bit 4 set clears status bits 1, 3 and 5 one cycle after the write, except those whose cause is still present and enabled. The clear request then drops by itself.
- R9: Latched status bits 1, 3 and 5 stay set after their cause disappears, until a clear.
- R10: The pull-down request is 1 exactly when any of status bits 1, 3 or 5 is set. Status bits 6 and 7 read 0.
- R11: The write select picks the register: 0 enables, 1 threshold, 2 control. Select 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 enables, 1 threshold, 2 control) |
| cfg_wdata | input | 8 | Write data |
| cur_valid | input | 1 | One-cycle strobe marking a new current result |
| cur_code | input | 12 | Current conversion code |
| cmp_oc_in | input | 1 | Asynchronous external comparator overcurrent level |
| status_o | output | 8 | Status byte for readback |
| alert_pd_o | output | 1 | Enable for the alert line pull-down |

## Verification
The properties assume that the result strobe lasts one cycle and that the current code is meaningful only on that cycle. They also assume that a clear is requested only through a write to the enable byte. The stimulus drives every input one time unit after a rising edge and holds each strobe or write for exactly one cycle. It moves the comparator input only between edges, so the synchronizer sees clean levels. Sticky-bit properties exclude the cycle in which a clear is pending, because that is the one place a latched bit is allowed to fall.

// File: rtl/oc_pkg.sv
package oc_pkg;
    localparam int REG_W = 8;

    // Register select values used on the write port
    localparam logic [1:0] SEL_ENABLE = 2'd0;
    localparam logic [1:0] SEL_THRESH = 2'd1;
    localparam logic [1:0] SEL_CTRL   = 2'd2;

    // Enable byte field positions
    localparam int EN_ADC_ONE  = 0;
    localparam int EN_ADC_RUN  = 1;
    localparam int EN_CMP      = 2;
    localparam int EN_SWOFF    = 3;
    localparam int EN_CLEAR    = 4;
    localparam int EN_W        = 5;

    typedef struct packed {
        logic [EN_W-2:0]  en;     // enables without the clear bit
        logic             clr;    // pending clear, self-clearing
        logic [REG_W-1:0] thr;
        logic             swoff;
    } cfg_t;

    typedef struct packed {
        logic adc;
        logic cmp;
        logic off;
    } latch_t;
endpackage

// File: rtl/oc_sync.sv
module oc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = d_in;
        for (int i = 1; i < STAGES; i++) begin
            sh_d[i] = sh_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q[g] <= 1'b0;
                else        sh_q[g] <= sh_d[g];
            end
        end
    endgenerate

    assign q_out = sh_q[STAGES-1];
endmodule

// File: rtl/oc_cfg_regs.sv
module oc_cfg_regs
    import oc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       sel,
    input  logic [REG_W-1:0] wdata,
    output cfg_t             cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d     = cfg_q;
        cfg_d.clr = 1'b0;   // a pending clear lasts one cycle
        if (we) begin
            unique case (sel)
                SEL_ENABLE: begin
                    cfg_d.en  = wdata[EN_W-2:0];
                    cfg_d.clr = wdata[EN_CLEAR];
                end
                SEL_THRESH: cfg_d.thr   = wdata;
                SEL_CTRL:   cfg_d.swoff = wdata[0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.en    <= 4'b0100;
            cfg_q.clr   <= 1'b0;
            cfg_q.thr   <= {REG_W{1'b1}};
            cfg_q.swoff <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/oc_adc_check.sv
module oc_adc_check #(
    parameter int CODE_W  = 12,
    parameter int THR_W   = 8,
    parameter int RUN_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [CODE_W-1:0] code,
    input  logic [THR_W-1:0]  thr,
    output logic              above,
    output logic              run_hit
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

    typedef struct packed {
        logic             above;
        logic [CNT_W-1:0] cnt;
    } chk_t;

    chk_t st_d, st_q;
    logic [THR_W-1:0] top_bits;
    logic             is_above;

    assign top_bits = code[CODE_W-1 -: THR_W];
    assign is_above = top_bits > thr;

    always_comb begin
        st_d = st_q;
        if (valid) begin
            st_d.above = is_above;
            if (!is_above)              st_d.cnt = '0;
            else if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign above   = st_q.above;
    assign run_hit = (st_q.cnt == CNT_MAX);
endmodule

// File: rtl/oc_alert_status.sv
module oc_alert_status
    import oc_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int THR_W       = 8,
    parameter int RUN_LEN     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [7:0]        cfg_wdata,
    input  logic              cur_valid,
    input  logic [CODE_W-1:0] cur_code,
    input  logic              cmp_oc_in,
    output logic [7:0]        status_o,
    output logic              alert_pd_o
);
    cfg_t   cfg_w;
    latch_t lat_d, lat_q;
    logic   adc_above, adc_run, cmp_s;
    logic   cause_adc, cause_cmp, cause_off, off_live;
    logic [EN_W-2:0] en_w;
    logic   clr_w;

    oc_cfg_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg   (cfg_w)
    );

    oc_adc_check #(
        .CODE_W  (CODE_W),
        .THR_W   (THR_W),
        .RUN_LEN (RUN_LEN)
    ) u_adc (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (cur_valid),
        .code    (cur_code),
        .thr     (cfg_w.thr),
        .above   (adc_above),
        .run_hit (adc_run)
    );

    oc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (cmp_oc_in),
        .q_out (cmp_s)
    );

    assign en_w  = cfg_w.en;
    assign clr_w = cfg_w.clr;

    always_comb begin
        off_live  = cfg_w.swoff & en_w[EN_SWOFF];
        cause_adc = (en_w[EN_ADC_ONE] & adc_above) | (en_w[EN_ADC_RUN] & adc_run);
        cause_cmp = en_w[EN_CMP] & cmp_s;
        cause_off = off_live;

        lat_d = lat_q;
        if (clr_w) begin
            lat_d.adc = cause_adc;
            lat_d.cmp = cause_cmp;
            lat_d.off = cause_off;
        end else begin
            lat_d.adc = lat_q.adc | cause_adc;
            lat_d.cmp = lat_q.cmp | cause_cmp;
            lat_d.off = lat_q.off | cause_off;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign status_o   = {2'b00, lat_q.off, off_live, lat_q.cmp, cmp_s, lat_q.adc, adc_above};
    assign alert_pd_o = lat_q.adc | lat_q.cmp | lat_q.off;
endmodule

// File: rtl/oc_alert_checker.sv
module oc_alert_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cur_valid,
    input logic [7:0] status,
    input logic       alert_pd,
    input logic [3:0] en,
    input logic       clr_pend
);
    // R2
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_valid |=> $stable(status[0]));

    // R9
    adc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && !clr_pend) |=> status[1]);

    // R9
    off_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[5] && !clr_pend) |=> status[5]);

    // R6
    cmp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[3] && !en[2]) |=> !status[3]);

    // R8
    clr_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pend |=> !clr_pend);

    // R10
    top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alert_pd |-> (status[7:6] == 2'b00 && status[5:1] != 5'd0));
endmodule

bind oc_alert_status oc_alert_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_valid (cur_valid),
    .status    (status_o),
    .alert_pd  (alert_pd_o),
    .en        (en_w),
    .clr_pend  (clr_w)
);

// File: tb/oc_alert_status_bench.sv
module oc_alert_status_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [7:0]  cfg_wdata = 8'd0;
    logic        cur_valid = 1'b0;
    logic [11:0] cur_code = 12'd0;
    logic        cmp_oc_in = 1'b0;
    logic [7:0]  status_o;
    logic        alert_pd_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] st;
        logic       pd;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    oc_alert_status u_oc_alert_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .cur_valid  (cur_valid),
        .cur_code   (cur_code),
        .cmp_oc_in  (cmp_oc_in),
        .status_o   (status_o),
        .alert_pd_o (alert_pd_o)
    );

    // monitor: compare every queued item at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            checks++;
            if (status_o !== it.st || alert_pd_o !== it.pd) begin
                fails++;
                $display("FAIL %s: status=%02h pd=%0b expected status=%02h pd=%0b",
                         it.tag, status_o, alert_pd_o, it.st, it.pd);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_st(input logic [7:0] st, input string tag);
        exp_t it;
        it.st  = st;
        it.pd  = |(st & 8'h2A);
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic strobe(input logic [11:0] code);
        cur_valid = 1'b1; cur_code = code;
        tick(1);
        cur_valid = 1'b0; cur_code = 12'hA5A;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        expect_st(8'h00, "R1 reset state");
        // default threshold 0xFF: full-scale code is not above
        strobe(12'hFFF); tick(1);
        expect_st(8'h00, "R1 default threshold full scale");

        wr(1, 8'h80);
        strobe(12'h80F); tick(1);
        expect_st(8'h00, "R2 equal is not above");
        strobe(12'h810); tick(1);
        expect_st(8'h01, "R2 above, not latched while disabled");
        wr(0, 8'h05); tick(1);
        expect_st(8'h03, "R3 single-result latch");
        strobe(12'h100); tick(1);
        expect_st(8'h02, "R9 latch sticky after cause gone");
        wr(0, 8'h15); tick(1);
        expect_st(8'h00, "R8 clear removes gone cause");

        // four in a row
        wr(0, 8'h06);
        repeat (3) strobe(12'h900);
        tick(1);
        expect_st(8'h01, "R4 three results not enough");
        strobe(12'h050); tick(1);
        expect_st(8'h00, "R4 low result restarts run");
        repeat (3) strobe(12'h900);
        tick(1);
        expect_st(8'h01, "R4 run restarted from zero");
        strobe(12'h900); tick(1);
        expect_st(8'h03, "R4 fourth consecutive latches");
        wr(0, 8'h16); tick(1);
        expect_st(8'h03, "R8 clear with cause present re-sets");
        strobe(12'h050); tick(1);
        expect_st(8'h02, "R9 run latch sticky");
        wr(0, 8'h16); tick(1);
        expect_st(8'h00, "R8 clear after cause gone");
        tick(2);
        expect_st(8'h00, "R8 clear request self-clears");

        // comparator path
        wr(0, 8'h04);
        cmp_oc_in = 1'b1;
        tick(1);
        expect_st(8'h00, "R5 one stage not yet visible");
        tick(1);
        expect_st(8'h04, "R5 live after two stages");
        tick(1);
        expect_st(8'h0C, "R5 comparator latch");
        cmp_oc_in = 1'b0;
        tick(2);
        expect_st(8'h08, "R9 comparator latch sticky");
        wr(0, 8'h14); tick(1);
        expect_st(8'h00, "R8 comparator clear");

        wr(0, 8'h00);
        cmp_oc_in = 1'b1;
        tick(3);
        expect_st(8'h04, "R6 no latch while disabled");
        cmp_oc_in = 1'b0;
        tick(2);
        expect_st(8'h00, "R6 live drops, nothing latched");

        // software off
        wr(2, 8'h01); tick(1);
        expect_st(8'h00, "R7 off inactive without enable");
        wr(0, 8'h08);
        expect_st(8'h10, "R7 off status follows enable");
        tick(1);
        expect_st(8'h30, "R7 off alert latches");
        wr(2, 8'h00);
        expect_st(8'h20, "R10 pull-down held by off latch");
        wr(0, 8'h18); tick(1);
        expect_st(8'h00, "R8 off clear");

        // select 3 writes nothing
        wr(3, 8'hFF);
        strobe(12'h810); tick(1);
        expect_st(8'h01, "R11 select 3 ignored");
        strobe(12'h7F0); tick(1);
        expect_st(8'h00, "R11 threshold kept at 0x80");

        tick(2);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule